// File: doc/BRIEF.md
# Hardware Thread Lifecycle Controller

This block is the system-side control state machine wrapped around a relocatable hardware thread. An operating-system scheduler sends it lifecycle commands: start, suspend, resume and stop, plus a relocate request. The user logic of the thread reports three events: the opening of a data transfer, the close of that transfer, and a blocking system call. From these the block tracks whether the running thread may be preempted. It drives an enable and a hold line into the user logic. It also reports its state, whether a suspend is waiting, and a one-cycle acknowledge for every command.

A running thread is either preemptible or non-preemptible. Opening a transfer makes it non-preemptible. Only an explicit end-of-transfer or blocking-call notice from the thread makes it preemptible again. While the thread is non-preemptible, relocation is refused. A suspend is not refused: it is parked, and it takes effect at the moment the thread becomes preemptible. Stop is always obeyed, and the enable to the user logic drops in the same cycle as the stop command.

Top module: `hw_thread_lifecycle`

## Requirements
- R1: After synchronous reset the state is IDLE (code 0), `usr_enable` and `usr_hold` are low, `ack_valid` is low and `susp_pending` is low.
- R2: START (command code 0) is accepted only in IDLE and moves to RUN_PRE (code 1). In any other state it is rejected and the state is unchanged.
- R3: `xfer_open` in RUN_PRE moves the thread to RUN_NOPRE (code 2). Thread events in IDLE, SUSPENDED (code 3) or STOPPED (code 4) have no effect.
- R4: From RUN_NOPRE the only ways out are `xfer_close` or `blk_call` (to RUN_PRE, or to SUSPENDED when a suspend is pending) and STOP. A suspend, relocate, resume or start does not leave RUN_NOPRE.
- R5: SUSPEND (code 1) in RUN_PRE is accepted and moves to SUSPENDED, where `usr_hold` is high and `usr_enable` is low. In IDLE, SUSPENDED or STOPPED it is rejected.
- R6: SUSPEND in RUN_NOPRE is acknowledged as deferred. `susp_pending` rises and the state is kept. On the next release event the state becomes SUSPENDED and `susp_pending` clears.
- R7: RELOCATE (code 4) is accepted in RUN_PRE or SUSPENDED, and the state becomes SUSPENDED. It is rejected in every other state, including RUN_NOPRE, and is never deferred.
- R8: RESUME (code 2) is accepted only in SUSPENDED and moves to RUN_PRE. Elsewhere it is rejected.
- R9: STOP (code 3) is accepted in every state and moves to STOPPED. It clears any pending suspend, and `usr_enable` is low in the same cycle that STOP is presented. Only reset leaves STOPPED.
- R10: Each cycle with `cmd_valid` high gives `ack_valid` high for exactly the following cycle. `ack_status` is 0 for accept, 1 for reject and 2 for deferred. Unknown command codes are rejected. There is no acknowledge without a command.
- R11: When a command and a thread event arrive in the same cycle, the command is evaluated first. A thread event acts only if the command left the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A scheduler command is present this cycle |
| cmd_code | input | CMD_W | Command code (0 start, 1 suspend, 2 resume, 3 stop, 4 relocate) |
| xfer_open | input | 1 | Thread opens a data transfer |
| xfer_close | input | 1 | Thread signals end of communication |
| blk_call | input | 1 | Thread makes a blocking system call |
| state_o | output | ST_W | Current lifecycle state code |
| preemptible | output | 1 | High in RUN_PRE |
| susp_pending | output | 1 | A deferred suspend is waiting |
| usr_enable | output | 1 | Run enable to the user logic |
| usr_hold | output | 1 | Hold to the user logic while suspended |
| ack_valid | output | 1 | One-cycle command acknowledge |
| ack_status | output | ACK_W | 0 accept, 1 reject, 2 deferred |

## Verification
The properties assume that `cmd_code` is meaningful only while `cmd_valid` is high. They also assume that thread events may arrive in any state, and in the same cycle as a command. The stimulus changes every input on the falling edge and holds at most one command per cycle. It deliberately pairs commands with thread events in the same cycle to exercise the ordering rule. The run also covers unknown command codes and events sent to stopped or idle threads.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int NUM_CMD = 5;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RUN_PRE  = 3'd1,
    ST_RUN_NOPR = 3'd2,
    ST_SUSP     = 3'd3,
    ST_STOP     = 3'd4
  } lc_state_e;

  typedef enum int {
    C_START  = 0,
    C_SUSP   = 1,
    C_RESUME = 2,
    C_STOP   = 3,
    C_RELOC  = 4
  } lc_cmd_e;

  typedef enum logic [1:0] {
    A_ACCEPT = 2'd0,
    A_REJECT = 2'd1,
    A_DEFER  = 2'd2
  } lc_ack_e;
endpackage

// File: rtl/lc_cmd_decode.sv
module lc_cmd_decode #(
  parameter int CMD_W = 3,
  parameter int NCMD  = lc_pkg::NUM_CMD
) (
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output logic [NCMD-1:0]  cmd_hit
);
  for (genvar i = 0; i < NCMD; i++) begin : g_hit
    assign cmd_hit[i] = cmd_valid && (cmd_code == CMD_W'(i));
  end
endmodule

// File: rtl/lc_fsm.sv
module lc_fsm
  import lc_pkg::*;
#(
  parameter int NCMD = lc_pkg::NUM_CMD
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [NCMD-1:0] cmd_hit,
  input  logic            xfer_open,
  input  logic            xfer_close,
  input  logic            blk_call,
  output lc_state_e       state_q,
  output lc_state_e       state_d,
  output logic            pend_q,
  output logic            ackv_q,
  output lc_ack_e         ack_q
);
  logic    pend_d;
  lc_ack_e ack_d;
  logic    release_ev;

  assign release_ev = xfer_close | blk_call;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    ack_d   = A_REJECT;
    // commands first
    if (cmd_hit[C_STOP]) begin
      state_d = ST_STOP;
      pend_d  = 1'b0;
      ack_d   = A_ACCEPT;
    end else if (cmd_hit[C_START]) begin
      if (state_q == ST_IDLE) begin
        state_d = ST_RUN_PRE;
        ack_d   = A_ACCEPT;
      end
    end else if (cmd_hit[C_SUSP]) begin
      if (state_q == ST_RUN_PRE) begin
        state_d = ST_SUSP;
        ack_d   = A_ACCEPT;
      end else if (state_q == ST_RUN_NOPR) begin
        pend_d = 1'b1;
        ack_d  = A_DEFER;
      end
    end else if (cmd_hit[C_RESUME]) begin
      if (state_q == ST_SUSP) begin
        state_d = ST_RUN_PRE;
        ack_d   = A_ACCEPT;
      end
    end else if (cmd_hit[C_RELOC]) begin
      if (state_q == ST_RUN_PRE || state_q == ST_SUSP) begin
        state_d = ST_SUSP;
        ack_d   = A_ACCEPT;
      end
    end
    // thread events only when the command left the state alone
    if (state_d == state_q) begin
      if (state_q == ST_RUN_PRE && xfer_open) begin
        state_d = ST_RUN_NOPR;
      end else if (state_q == ST_RUN_NOPR && release_ev) begin
        state_d = pend_d ? ST_SUSP : ST_RUN_PRE;
        pend_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      ackv_q  <= 1'b0;
      ack_q   <= A_ACCEPT;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      ackv_q  <= cmd_valid;
      ack_q   <= cmd_valid ? ack_d : A_ACCEPT;
    end
  end
endmodule

// File: rtl/lc_user_ctrl.sv
module lc_user_ctrl
  import lc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lc_state_e state_d,
  input  logic      stop_now,
  output logic      usr_enable,
  output logic      usr_hold
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      usr_hold <= 1'b0;
    end else begin
      en_q     <= (state_d == ST_RUN_PRE) || (state_d == ST_RUN_NOPR);
      usr_hold <= (state_d == ST_SUSP);
    end
  end

  // a stop drops the enable in the cycle it is presented
  assign usr_enable = en_q & ~stop_now;
endmodule

// File: rtl/hw_thread_lifecycle.sv
module hw_thread_lifecycle
  import lc_pkg::*;
#(
  parameter int CMD_W = 3,
  parameter int ST_W  = 3,
  parameter int ACK_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             xfer_open,
  input  logic             xfer_close,
  input  logic             blk_call,
  output logic [ST_W-1:0]  state_o,
  output logic             preemptible,
  output logic             susp_pending,
  output logic             usr_enable,
  output logic             usr_hold,
  output logic             ack_valid,
  output logic [ACK_W-1:0] ack_status
);
  localparam int NCMD = NUM_CMD;

  logic [NCMD-1:0] cmd_hit;
  lc_state_e       st_q, st_d;
  lc_ack_e         ack_q;

  lc_cmd_decode #(.CMD_W(CMD_W), .NCMD(NCMD)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_hit   (cmd_hit)
  );

  lc_fsm #(.NCMD(NCMD)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_hit    (cmd_hit),
    .xfer_open  (xfer_open),
    .xfer_close (xfer_close),
    .blk_call   (blk_call),
    .state_q    (st_q),
    .state_d    (st_d),
    .pend_q     (susp_pending),
    .ackv_q     (ack_valid),
    .ack_q      (ack_q)
  );

  lc_user_ctrl u_usr (
    .clk        (clk),
    .rst        (rst),
    .state_d    (st_d),
    .stop_now   (cmd_hit[C_STOP]),
    .usr_enable (usr_enable),
    .usr_hold   (usr_hold)
  );

  assign state_o     = ST_W'(st_q);
  assign preemptible = (st_q == ST_RUN_PRE);
  assign ack_status  = ACK_W'(ack_q);
endmodule

// File: rtl/hw_thread_lifecycle_chk.sv
module hw_thread_lifecycle_chk #(
  parameter int CMD_W = 3,
  parameter int ST_W  = 3,
  parameter int ACK_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_code,
  input logic             xfer_close,
  input logic             blk_call,
  input logic [ST_W-1:0]  state_o,
  input logic             susp_pending,
  input logic             usr_enable,
  input logic             usr_hold,
  input logic             ack_valid
);
  logic stop_c;
  assign stop_c = cmd_valid && (cmd_code == CMD_W'(3));

  a_r10_ack_follows: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> ack_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !ack_valid);
  a_r9_stop_enable: assert property (@(posedge clk) disable iff (rst)
    stop_c |-> !usr_enable);
  a_r9_stop_state: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> state_o == ST_W'(4));
  a_r4_np_sticky: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_W'(2) && !xfer_close && !blk_call && !stop_c)
      |=> state_o == ST_W'(2));
  a_r6_pending_np: assert property (@(posedge clk) disable iff (rst)
    susp_pending |-> state_o == ST_W'(2));
  a_r5_hold_excl: assert property (@(posedge clk) disable iff (rst)
    usr_hold |-> !usr_enable);
  a_r8_resume: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_W'(3) && cmd_valid && cmd_code == CMD_W'(2))
      |=> state_o == ST_W'(1));
endmodule

bind hw_thread_lifecycle hw_thread_lifecycle_chk #(
  .CMD_W(CMD_W), .ST_W(ST_W), .ACK_W(ACK_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_valid    (cmd_valid),
  .cmd_code     (cmd_code),
  .xfer_close   (xfer_close),
  .blk_call     (blk_call),
  .state_o      (state_o),
  .susp_pending (susp_pending),
  .usr_enable   (usr_enable),
  .usr_hold     (usr_hold),
  .ack_valid    (ack_valid)
);

// File: tb/hw_thread_lifecycle_test.sv
module hw_thread_lifecycle_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic       xfer_open = 1'b0, xfer_close = 1'b0, blk_call = 1'b0;
  logic [2:0] state_o;
  logic       preemptible, susp_pending, usr_enable, usr_hold, ack_valid;
  logic [1:0] ack_status;
  int         n_chk = 0, n_fail = 0;
  logic       done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  hw_thread_lifecycle uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .xfer_open(xfer_open), .xfer_close(xfer_close), .blk_call(blk_call),
    .state_o(state_o), .preemptible(preemptible), .susp_pending(susp_pending),
    .usr_enable(usr_enable), .usr_hold(usr_hold), .ack_valid(ack_valid),
    .ack_status(ack_status)
  );

  // fields: valid | cmd[2:0] | open close blk | state[2:0] | ackv | ack[1:0] | en | pend
  localparam int NV = 29;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1,3'd2,3'b000,3'd0,1'b1,2'd1,1'b0,1'b0}, // R8 resume in idle rejected
    {1'b1,3'd1,3'b000,3'd0,1'b1,2'd1,1'b0,1'b0}, // R5 suspend in idle rejected
    {1'b1,3'd0,3'b000,3'd1,1'b1,2'd0,1'b1,1'b0}, // R2 start
    {1'b1,3'd0,3'b000,3'd1,1'b1,2'd1,1'b1,1'b0}, // R2 second start rejected
    {1'b0,3'd0,3'b100,3'd2,1'b0,2'd0,1'b1,1'b0}, // R3 transfer opens
    {1'b1,3'd4,3'b000,3'd2,1'b1,2'd1,1'b1,1'b0}, // R7 relocate refused
    {1'b1,3'd1,3'b000,3'd2,1'b1,2'd2,1'b1,1'b1}, // R6 suspend deferred
    {1'b0,3'd0,3'b000,3'd2,1'b0,2'd0,1'b1,1'b1}, // R10 no ack when idle
    {1'b0,3'd0,3'b010,3'd3,1'b0,2'd0,1'b0,1'b0}, // R6 close applies pending
    {1'b1,3'd2,3'b000,3'd1,1'b1,2'd0,1'b1,1'b0}, // R8 resume
    {1'b0,3'd0,3'b100,3'd2,1'b0,2'd0,1'b1,1'b0}, // R3
    {1'b0,3'd0,3'b001,3'd1,1'b0,2'd0,1'b1,1'b0}, // R4 blocking call releases
    {1'b1,3'd1,3'b000,3'd3,1'b1,2'd0,1'b0,1'b0}, // R5 suspend accepted
    {1'b1,3'd4,3'b000,3'd3,1'b1,2'd0,1'b0,1'b0}, // R7 relocate while suspended
    {1'b1,3'd2,3'b000,3'd1,1'b1,2'd0,1'b1,1'b0}, // R8
    {1'b1,3'd4,3'b000,3'd3,1'b1,2'd0,1'b0,1'b0}, // R7 relocate while preemptible
    {1'b1,3'd2,3'b000,3'd1,1'b1,2'd0,1'b1,1'b0}, // R8
    {1'b1,3'd1,3'b100,3'd3,1'b1,2'd0,1'b0,1'b0}, // R11 suspend beats open
    {1'b1,3'd2,3'b000,3'd1,1'b1,2'd0,1'b1,1'b0}, // R8
    {1'b0,3'd0,3'b100,3'd2,1'b0,2'd0,1'b1,1'b0}, // R3
    {1'b1,3'd1,3'b010,3'd3,1'b1,2'd2,1'b0,1'b0}, // R11 deferred then close
    {1'b1,3'd2,3'b000,3'd1,1'b1,2'd0,1'b1,1'b0}, // R8
    {1'b0,3'd0,3'b100,3'd2,1'b0,2'd0,1'b1,1'b0}, // R3
    {1'b1,3'd1,3'b000,3'd2,1'b1,2'd2,1'b1,1'b1}, // R6
    {1'b1,3'd3,3'b000,3'd4,1'b1,2'd0,1'b0,1'b0}, // R9 stop clears pending
    {1'b1,3'd0,3'b000,3'd4,1'b1,2'd1,1'b0,1'b0}, // R2 start after stop
    {1'b1,3'd2,3'b000,3'd4,1'b1,2'd1,1'b0,1'b0}, // R8 resume after stop
    {1'b0,3'd0,3'b111,3'd4,1'b0,2'd0,1'b0,1'b0}, // R3 events ignored
    {1'b1,3'd7,3'b000,3'd4,1'b1,2'd1,1'b0,1'b0}  // R10 unknown code
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] c, input logic [2:0] ev);
    @(negedge clk);
    cmd_valid  = v;
    cmd_code   = c;
    xfer_open  = ev[2];
    xfer_close = ev[1];
    blk_call   = ev[0];
  endtask

  task automatic check_reset();
    chk("R1", "state", state_o, 0);
    chk("R1", "enable", usr_enable, 0);
    chk("R1", "hold", usr_hold, 0);
    chk("R1", "ack_valid", ack_valid, 0);
    chk("R1", "pending", susp_pending, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check_reset();
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [14:0] e;
      e = VEC[i];
      drive(e[14], e[13:11], e[10:8]);
      @(posedge clk); #1;
      chk("vector", "state", state_o, e[7:5]);
      chk("vector", "ack_valid", ack_valid, e[4]);
      if (e[4]) chk("vector", "ack_status", ack_status, e[3:2]);
      chk("vector", "enable", usr_enable, e[1]);
      chk("vector", "hold", usr_hold, (e[7:5] == 3'd3));
      chk("vector", "pending", susp_pending, e[0]);
      chk("vector", "preemptible", preemptible, (e[7:5] == 3'd1));
    end
    // R1: reset again from STOPPED
    drive(1'b0, 3'd0, 3'b000);
    rst = 1'b1;
    @(posedge clk); #1 check_reset();
    @(negedge clk) rst = 1'b0;
    // R9: enable drops in the same cycle as stop
    drive(1'b1, 3'd0, 3'b000);
    drive(1'b0, 3'd0, 3'b100);
    drive(1'b1, 3'd3, 3'b000);
    #1 chk("R9", "same-cycle enable", usr_enable, 0);
    @(posedge clk); #1 chk("R9", "stopped", state_o, 4);
    drive(1'b0, 3'd0, 3'b000);
    @(posedge clk); #1 chk("R10", "ack pulse ends", ack_valid, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule